// File: doc/BRIEF.md
# ADC Conversion Sequencer and Result Formatter

This block is the digital half of a successive-approximation ADC peripheral. A byte-wide register bus sets it up. Through that bus software picks an input channel and powers the block up. It also selects how the raw 10-bit code is laid out in two result bytes and whether conversions repeat. The block divides the bus clock into a conversion clock enable. It starts and aborts conversions on a simple start/done port to an external converter, and it formats the returned code into the result bytes.

Every completed conversion sets a done flag, and when interrupts are enabled that flag raises an interrupt request. Reading either result byte clears the flag, and so does writing the status/control register. Each of the three writable registers treats a running conversion in its own way. If an input's pin-enable bit is clear, a conversion on that input yields a zero result and the converter is never started.

Top module: `adc_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `irq` is low and `conv_tick` stays low because the block is powered down.
- R2: While powered, `conv_tick` pulses for one cycle once every (P+1)*2 bus cycles, where P is the prescale field, bits 7:4 of the setup register at address 3.
- R3: A write to the setup register (address 3; bit 3 power, bit 2 right-justify, bit 1 eight-bit, bit 0 signed) aborts a running conversion. If the written power bit is 1, the write starts a new conversion with no other write.
- R4: A write to the status/control register (address 0; bits 4:0 channel, bit 5 repeat, bit 6 interrupt enable, bit 7 read-only done flag) clears the done flag. When powered it starts a new conversion on the written channel.
- R5: A write to the pin-enable register (address 4, bit n for input n) aborts a running conversion and starts none.
- R6: The done flag is set when a conversion ends. A read of result byte high (address 1) or low (address 2) clears it.
- R7: `irq` is high exactly when the done flag and the interrupt enable are both set.
- R8: In repeat mode a new conversion starts on the first conversion clock pulse after the flag is set. In single mode no further conversion starts.
- R9: Selecting input 0 to 7 while its pin-enable bit is 0 loads 0x00 into both result bytes, sets the flag and never asserts `conv_start`.
- R10: `conv_sel` carries codes 0x00 to 0x07 and 0x1E unchanged. Codes 0x08 to 0x1D map to 0x1F, the low reference.
- R11: In 10-bit mode, left-justified puts raw[9:2] in the high byte and raw[1:0] in low bits 7:6. Right-justified puts raw[9:8] in high bits 1:0 and raw[7:0] in the low byte. Unused bits read 0.
- R12: In 8-bit mode raw[9:2] goes to the high byte and the low byte reads 0, whatever the justify bit says.
- R13: The signed bit inverts the MSB of a left-justified result (0x3FF gives high 0x7F, 0x000 gives 0x80). It has no effect when right-justified.
- R14: Clearing the power bit aborts a running conversion, stops `conv_tick` and prevents any done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on result bytes) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| conv_tick | output | 1 | Conversion clock enable pulse |
| conv_start | output | 1 | Start pulse to converter |
| conv_abort | output | 1 | Abort pulse to converter |
| conv_sel | output | 5 | Mapped input select |
| conv_done | input | 1 | Converter finished pulse |
| conv_code | input | 10 | Raw converted code, valid with conv_done |

## Verification
A wrong sequencer state shows at the ports within one conversion. Either the done flag never rises, which a bounded poll catches, or a write that should abort is followed by a stray flag or a `conv_start` pulse on the very next cycle. Formatting faults show at the first read of the result bytes after the flag rises, because each justification, resolution and sign mix is read back against a known raw code. A wrong prescale count shows in the spacing of `conv_tick` pulses within one divider period.

// File: rtl/adc_pkg.sv
package adc_pkg;
    localparam int RAW_W   = 10;
    localparam int BYTE_W  = 8;
    localparam int CH_W    = 5;
    localparam int PRS_W   = 4;
    localparam int NPINS   = 8;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RHI   = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SETUP = 3'd3;
    localparam logic [ADDR_W-1:0] A_PINEN = 3'd4;

    localparam logic [CH_W-1:0] CH_VHI = 5'h1E;
    localparam logic [CH_W-1:0] CH_VLO = 5'h1F;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_BUSY,
        ST_GAP
    } seq_st_e;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int PRS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);
    localparam int CNT_W = PRS_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    // (prs+1)*2-1 == 2*prs+1
    assign last = {prs, 1'b1};
    assign tick = en && (cnt_q >= last);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_formatter.sv
module adc_formatter #(
    parameter int RAW_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic              rjust,
    input  logic              res8,
    input  logic              sgn,
    output logic [BYTE_W-1:0] hi,
    output logic [BYTE_W-1:0] lo
);
    localparam int SPILL = RAW_W - BYTE_W;

    logic [BYTE_W-1:0] top;

    always_comb begin
        top = raw[RAW_W-1 -: BYTE_W];
        if (sgn && !rjust) top[BYTE_W-1] = ~top[BYTE_W-1];
        hi = '0;
        lo = '0;
        if (res8) begin
            hi = top;
        end else if (rjust) begin
            hi[SPILL-1:0] = raw[RAW_W-1 -: SPILL];
            lo            = raw[BYTE_W-1:0];
        end else begin
            hi                    = top;
            lo[BYTE_W-1 -: SPILL] = raw[SPILL-1:0];
        end
    end
endmodule

// File: rtl/adc_chan_map.sv
module adc_chan_map #(
    parameter int CH_W  = 5,
    parameter int NPINS = 8
) (
    input  logic [CH_W-1:0]  chan,
    input  logic [NPINS-1:0] pin_en,
    output logic [CH_W-1:0]  sel,
    output logic             blocked
);
    import adc_pkg::*;
    localparam int PIDX_W = $clog2(NPINS);

    logic is_pin;
    assign is_pin = (chan < CH_W'(NPINS));

    always_comb begin
        if (is_pin || chan == CH_VHI) sel = chan;
        else                          sel = CH_VLO;
        blocked = is_pin && !pin_en[chan[PIDX_W-1:0]];
    end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
    import adc_pkg::*;
#(
    parameter int P_RAW_W  = RAW_W,
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_CH_W   = CH_W,
    parameter int P_PRS_W  = PRS_W,
    parameter int P_NPINS  = NPINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [P_BYTE_W-1:0] wdata,
    output logic [P_BYTE_W-1:0] rdata,
    output logic                irq,
    output logic                conv_tick,
    output logic                conv_start,
    output logic                conv_abort,
    output logic [P_CH_W-1:0]   conv_sel,
    input  logic                conv_done,
    input  logic [P_RAW_W-1:0]  conv_code
);
    typedef struct packed {
        logic                pwr;
        logic                rjust;
        logic                res8;
        logic                sgn;
        logic [P_PRS_W-1:0]  prs;
        logic                flag;
        logic                ie;
        logic                rep;
        logic [P_CH_W-1:0]   chan;
        logic [P_NPINS-1:0]  pin_en;
        logic [P_BYTE_W-1:0] res_hi;
        logic [P_BYTE_W-1:0] res_lo;
        seq_st_e             st;
    } state_t;

    state_t q, d;

    logic [P_BYTE_W-1:0] fmt_hi, fmt_lo;
    logic                blocked;
    logic                wr_seq;
    logic                rd_res;
    logic                pwr_w, flag_w, launch_w;

    adc_prescaler #(.PRS_W(P_PRS_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (q.pwr),
        .prs  (q.prs),
        .tick (conv_tick)
    );

    adc_formatter #(.RAW_W(P_RAW_W), .BYTE_W(P_BYTE_W)) u_fmt (
        .raw  (conv_code),
        .rjust(q.rjust),
        .res8 (q.res8),
        .sgn  (q.sgn),
        .hi   (fmt_hi),
        .lo   (fmt_lo)
    );

    adc_chan_map #(.CH_W(P_CH_W), .NPINS(P_NPINS)) u_map (
        .chan   (q.chan),
        .pin_en (q.pin_en),
        .sel    (conv_sel),
        .blocked(blocked)
    );

    assign wr_seq = wr_en && (addr == A_STAT || addr == A_SETUP || addr == A_PINEN);
    assign rd_res = rd_en && (addr == A_RHI || addr == A_RLO);

    assign conv_start = (q.st == ST_LAUNCH) && !blocked && !wr_seq;
    assign conv_abort = (q.st == ST_BUSY) && wr_seq;
    assign irq        = q.flag && q.ie;

    assign pwr_w    = q.pwr;
    assign flag_w   = q.flag;
    assign launch_w = (q.st == ST_LAUNCH);

    always_comb begin
        rdata = '0;
        case (addr)
            A_STAT:  rdata = {q.flag, q.ie, q.rep, q.chan};
            A_RHI:   rdata = q.res_hi;
            A_RLO:   rdata = q.res_lo;
            A_SETUP: rdata = {q.prs, q.pwr, q.rjust, q.res8, q.sgn};
            A_PINEN: rdata = q.pin_en;
            default: rdata = '0;
        endcase
    end

    always_comb begin
        d = q;
        if (rd_res) d.flag = 1'b0;

        case (q.st)
            ST_LAUNCH: begin
                if (blocked) begin
                    d.res_hi = '0;
                    d.res_lo = '0;
                    d.flag   = 1'b1;
                    d.st     = q.rep ? ST_GAP : ST_IDLE;
                end else begin
                    d.st = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (conv_done) begin
                    d.res_hi = fmt_hi;
                    d.res_lo = fmt_lo;
                    d.flag   = 1'b1;
                    d.st     = q.rep ? ST_GAP : ST_IDLE;
                end
            end
            ST_GAP: begin
                if (conv_tick) d.st = ST_LAUNCH;
            end
            default: d.st = ST_IDLE;
        endcase

        if (wr_en) begin
            case (addr)
                A_STAT: begin
                    d.chan = wdata[P_CH_W-1:0];
                    d.rep  = wdata[5];
                    d.ie   = wdata[6];
                    d.flag = 1'b0;
                    d.st   = q.pwr ? ST_LAUNCH : ST_IDLE;
                end
                A_SETUP: begin
                    d.prs   = wdata[7:4];
                    d.pwr   = wdata[3];
                    d.rjust = wdata[2];
                    d.res8  = wdata[1];
                    d.sgn   = wdata[0];
                    d.st    = wdata[3] ? ST_LAUNCH : ST_IDLE;
                end
                A_PINEN: begin
                    d.pin_en = wdata[P_NPINS-1:0];
                    d.st     = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic       conv_tick,
    input logic       conv_start,
    input logic [4:0] conv_sel,
    input logic       conv_done,
    input logic       pwr_w,
    input logic       flag_w,
    input logic       launch_w
);
    p_tick_off_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_w |-> !conv_tick);

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_tick |=> !conv_tick);

    p_sel_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_sel < 5'd8 || conv_sel >= 5'h1E));

    p_stat_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> !flag_w);

    p_pin_nostart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4) |=> !conv_start);

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (addr == 3'd1 || addr == 3'd2) && !conv_done && !launch_w)
        |=> !flag_w);
endmodule

bind adc_ctrl adc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .conv_tick (conv_tick),
    .conv_start(conv_start),
    .conv_sel  (conv_sel),
    .conv_done (conv_done),
    .pwr_w     (pwr_w),
    .flag_w    (flag_w),
    .launch_w  (launch_w)
);

// File: tb/tb_adc_ctrl.sv
module tb_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, conv_tick, conv_start, conv_abort;
    logic [4:0] conv_sel;
    logic       conv_done = 1'b0;
    logic [9:0] conv_code = 10'd0;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    int start_cnt = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .conv_tick(conv_tick),
        .conv_start(conv_start), .conv_abort(conv_abort), .conv_sel(conv_sel),
        .conv_done(conv_done), .conv_code(conv_code)
    );

    // converter model: three conversion clock pulses per conversion
    logic       m_busy = 1'b0;
    logic [1:0] m_cnt = 2'd0;
    logic [4:0] m_sel = 5'd0;

    function automatic logic [9:0] analog(input logic [4:0] s);
        case (s)
            5'h00: return 10'h2B7;
            5'h03: return 10'h1C4;
            5'h05: return 10'h0F3;
            5'h1E: return 10'h3FF;
            5'h1F: return 10'h000;
            default: return 10'h155;
        endcase
    endfunction

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            m_busy <= 1'b0;
        end else if (conv_start) begin
            m_busy <= 1'b1;
            m_cnt  <= 2'd0;
            m_sel  <= conv_sel;
        end else if (conv_abort) begin
            m_busy <= 1'b0;
        end else if (m_busy && conv_tick) begin
            if (m_cnt == 2'd2) begin
                m_busy    <= 1'b0;
                conv_done <= 1'b1;
                conv_code <= analog(m_sel);
            end else begin
                m_cnt <= m_cnt + 2'd1;
            end
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (conv_tick) tick_cnt <= tick_cnt + 1;
        if (conv_start) start_cnt <= start_cnt + 1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_flag(input int limit, output logic seen);
        logic [7:0] s;
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            rd(3'd0, s);
            seen = s[7];
        end
    endtask

    // vector: setup value, channel, expected high, expected low
    localparam int NV = 12;
    localparam logic [28:0] VEC [NV] = '{
        {8'h08, 5'h00, 8'hAD, 8'hC0},
        {8'h09, 5'h00, 8'h2D, 8'hC0},
        {8'h0C, 5'h00, 8'h02, 8'hB7},
        {8'h0D, 5'h00, 8'h02, 8'hB7},
        {8'h0A, 5'h00, 8'hAD, 8'h00},
        {8'h0B, 5'h00, 8'h2D, 8'h00},
        {8'h0E, 5'h00, 8'hAD, 8'h00},
        {8'h19, 5'h1E, 8'h7F, 8'hC0},
        {8'h09, 5'h1F, 8'h80, 8'h00},
        {8'h08, 5'h10, 8'h00, 8'h00},
        {8'h08, 5'h03, 8'h00, 8'h00},
        {8'h08, 5'h05, 8'h3C, 8'hC0}
    };

    function automatic string vtag(input int i);
        case (i)
            0, 11: return "R11 left10";
            1:     return "R13 signed left10";
            2:     return "R11 right10";
            3:     return "R13 sign ignored right";
            4, 6:  return "R12 eight-bit";
            5:     return "R13 signed eight-bit";
            7, 8:  return "R13 reference extremes";
            9:     return "R10 reserved code";
            default: return "R9 disabled pin";
        endcase
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v, lo;
        logic seen;
        int t0, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 8'h00, "R1 register reset", v, 0);
        end
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        t0 = tick_cnt;
        repeat (40) @(negedge clk);
        chk(tick_cnt == t0, "R1 no tick when unpowered", tick_cnt - t0, 0);

        wr(3'd4, 8'hF7);

        for (int i = 0; i < NV; i++) begin
            wr(3'd3, VEC[i][28:21]);
            wr(3'd0, {3'b000, VEC[i][20:16]});
            wait_flag(200, seen);
            chk(seen, {vtag(i), " flag"}, seen, 1);
            rd(3'd1, v);
            rd(3'd2, lo);
            chk(v == VEC[i][15:8], {vtag(i), " high"}, v, VEC[i][15:8]);
            chk(lo == VEC[i][7:0], {vtag(i), " low"}, lo, VEC[i][7:0]);
        end

        // R9 no converter start on disabled pin
        t0 = start_cnt;
        wr(3'd0, 8'h03);
        wait_flag(50, seen);
        chk(seen && start_cnt == t0, "R9 no start", start_cnt - t0, 0);

        // R6 read of either byte clears flag
        wr(3'd0, 8'h00);
        wait_flag(200, seen);
        rd(3'd2, v);
        rd(3'd0, v);
        chk(v[7] == 1'b0, "R6 low read clears", v[7], 0);
        wr(3'd0, 8'h00);
        wait_flag(200, seen);
        rd(3'd1, v);
        rd(3'd0, v);
        chk(v[7] == 1'b0, "R6 high read clears", v[7], 0);

        // R7 interrupt
        wr(3'd0, 8'h40);
        wait_flag(200, seen);
        #1 chk(irq == 1'b1, "R7 irq with enable", irq, 1);
        rd(3'd2, v);
        #1 chk(irq == 1'b0, "R7 irq after clear", irq, 0);
        wr(3'd0, 8'h00);
        wait_flag(200, seen);
        #1 chk(irq == 1'b0, "R7 irq masked", irq, 0);

        // R4 status write clears flag
        wr(3'd0, 8'h00);
        rd(3'd0, v);
        chk(v[7] == 1'b0, "R4 status write clears", v[7], 0);
        wait_flag(200, seen);
        chk(seen, "R4 status write starts", seen, 1);

        // R8 repeat mode re-arms, single mode stops
        wr(3'd0, 8'h20);
        wait_flag(200, seen);
        rd(3'd1, v);
        wait_flag(200, seen);
        chk(seen, "R8 repeat restarts", seen, 1);
        wr(3'd0, 8'h00);
        wait_flag(200, seen);
        rd(3'd1, v);
        t0 = start_cnt;
        repeat (150) @(negedge clk);
        rd(3'd0, v);
        chk(v[7] == 1'b0 && start_cnt == t0, "R8 single stays idle", start_cnt - t0, 0);

        // R3 setup write starts a conversion
        wr(3'd3, 8'h08);
        wait_flag(200, seen);
        chk(seen, "R3 setup write starts", seen, 1);
        rd(3'd1, v);

        // R5 pin-enable write aborts without restart
        wr(3'd3, 8'hF8);
        wr(3'd0, 8'h00);
        repeat (10) @(negedge clk);
        t0 = start_cnt;
        wr(3'd4, 8'hF7);
        repeat (400) @(negedge clk);
        rd(3'd0, v);
        chk(v[7] == 1'b0 && start_cnt == t0, "R5 pin write aborts", v, 0);

        // R2 prescale period with P=2
        wr(3'd3, 8'h20);
        wr(3'd3, 8'h28);
        while (!conv_tick) @(negedge clk);
        @(negedge clk);
        p = 1;
        while (!conv_tick && p < 100) begin @(negedge clk); p++; end
        chk(p == 6, "R2 tick period", p, 6);

        // R14 power off aborts and stops clock
        wr(3'd3, 8'hF8);
        wr(3'd0, 8'h00);
        repeat (20) @(negedge clk);
        wr(3'd3, 8'hF0);
        t0 = tick_cnt;
        repeat (300) @(negedge clk);
        rd(3'd0, v);
        chk(v[7] == 1'b0, "R14 no flag after power off", v, 0);
        chk(tick_cnt == t0, "R14 no ticks", tick_cnt - t0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule